// File: doc/BRIEF.md
# Masked Interrupt Aggregator

This block gathers single-cycle event pulses from five sources (two timer underflows, a time-of-day alarm, a serial shift completion and an external edge input) into a byte of sticky pending flags. A software-programmable enable mask selects which pending flags may raise the interrupt request. The request drives an active-low, level-sensitive interrupt line toward the processor.

Software sees the block through a single register location. A write changes the enable mask. The top data bit of the write chooses whether the ones in the low bits set or clear mask bits. A read returns the pending flags, with the request summary in the top bit. The same read then clears every flag and drops the request. Events that arrive while their source is disabled are still recorded, so enabling that source later raises the request straight away.

Top module: `evt_irq_ctrl`

## Requirements
- R1: The read byte carries the pending flags in fixed positions: bit 0 timer A, bit 1 timer B, bit 2 alarm, bit 3 serial, bit 4 external input, bit 7 request summary (equal to the inverse of `irq_n`). Bits 6 and 5 always read 0.
- R2: On a write with `wr_data[7]` = 1, each 1 in `wr_data[4:0]` sets the matching enable bit. On a write with `wr_data[7]` = 0, each 1 in `wr_data[4:0]` clears the matching enable bit. Enable bits matching a 0 are left unchanged.
- R3: An event pulse in a cycle sets its flag after that clock edge, whether or not its enable bit is set. A disabled flag alone never raises the request.
- R4: When a pending flag has its enable bit set, the request rises after that edge. Further events while the request is active leave it asserted and cause no new transition.
- R5: A read presents the current flags and request in the cycle it is issued. After that edge, all flags are 0 and `irq_n` is 1, unless R8 applies.
- R6: A write that enables a source whose flag is already pending raises the request after the write edge.
- R7: Reset clears the enable mask and the flags, and drives `irq_n` to 1. An event after reset on a previously enabled source raises no request.
- R8: An event in the same cycle as a read survives the clear as a pending flag. If its enable bit is set, the request is asserted again after that edge.
- R9: `irq_n` is a level. Once low, it stays low on every cycle until a read, not just for one cycle.
- R10: Clearing enable bits while the request is active does not drop the request. Only a read drops it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 5 | Single-cycle event pulses, one per source, in R1 bit order |
| reg_wr | input | 1 | Write strobe for the enable mask |
| reg_rd | input | 1 | Read strobe; clears flags and request at the edge |
| wr_data | input | 8 | Write data: bit 7 selects set or clear, bits 4:0 select sources |
| rd_data | output | 8 | Pending flags and request summary |
| irq_n | output | 1 | Active-low level interrupt request |

## Verification
The bench builds the block with its default parameters: five sources and an eight-bit register. With these values the set/clear selector sits in bit 7 and two unused bits lie between the flags and the summary bit. This lets the bench check that the unused read bits stay 0 and that set/clear writes with stray ones in bits 6:5 do no harm. The vector walk drives reads that coincide with events and mask writes against pending flags. Directed tests then cover a mid-run reset and a long hold of the request line.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  // Bit positions of the event sources in flags, mask and read byte.
  typedef enum int {
    SRC_TMR_A  = 0,
    SRC_TMR_B  = 1,
    SRC_ALARM  = 2,
    SRC_SERIAL = 3,
    SRC_EXTIN  = 4
  } src_pos_e;

  localparam int DEF_NUM_SRC = 5;
  localparam int DEF_REG_W   = 8;
endpackage

// File: rtl/evt_irq_flag_bank.sv
module evt_irq_flag_bank #(
  parameter int NUM_SRC = evt_irq_pkg::DEF_NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               clr,
  output logic [NUM_SRC-1:0] flags_q,
  output logic [NUM_SRC-1:0] flags_nx
);
  // A same-cycle event wins over the clear, so it is never lost.
  function automatic logic flag_step(input logic cur, input logic hit, input logic wipe);
    return (cur & ~wipe) | hit;
  endfunction

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    assign flags_nx[i] = flag_step(flags_q[i], evt[i], clr);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= flags_nx[i];
    end
  end
endmodule

// File: rtl/evt_irq_mask_reg.sv
module evt_irq_mask_reg #(
  parameter int NUM_SRC = evt_irq_pkg::DEF_NUM_SRC,
  parameter int REG_W   = evt_irq_pkg::DEF_REG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [REG_W-1:0]   wr_data,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] mask_nx
);
  localparam int SEL_BIT = REG_W - 1;

  // Set or clear one enable bit according to the selector.
  function automatic logic mask_step(input logic cur, input logic we,
                                     input logic sel_set, input logic pick);
    if (!we || !pick) return cur;
    return sel_set;
  endfunction

  logic unused_gap_bits;
  if (SEL_BIT > NUM_SRC) begin : g_gap
    assign unused_gap_bits = ^wr_data[SEL_BIT-1:NUM_SRC];
  end else begin : g_nogap
    assign unused_gap_bits = 1'b0;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_mask
    assign mask_nx[i] = mask_step(mask_q[i], wr, wr_data[SEL_BIT], wr_data[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q[i] <= 1'b0;
      else        mask_q[i] <= mask_nx[i];
    end
  end
endmodule

// File: rtl/evt_irq_req_gen.sv
module evt_irq_req_gen #(
  parameter int NUM_SRC = evt_irq_pkg::DEF_NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [NUM_SRC-1:0] flags_nx,
  input  logic [NUM_SRC-1:0] mask_nx,
  output logic               raise,
  output logic               req_q
);
  // Any enabled pending flag after this edge.
  function automatic logic any_enabled(input logic [NUM_SRC-1:0] f,
                                       input logic [NUM_SRC-1:0] m);
    return |(f & m);
  endfunction

  // The request is sticky: only a read drops it.
  function automatic logic req_step(input logic cur, input logic wipe, input logic hit);
    return (cur & ~wipe) | hit;
  endfunction

  assign raise = any_enabled(flags_nx, mask_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_step(req_q, clr, raise);
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int NUM_SRC = evt_irq_pkg::DEF_NUM_SRC,
  parameter int REG_W   = evt_irq_pkg::DEF_REG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  output logic               irq_n
);
  localparam int GAP_W = REG_W - 1 - NUM_SRC;

  logic [NUM_SRC-1:0] flags_q;
  logic [NUM_SRC-1:0] flags_nx;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] mask_nx;
  logic               req_q;
  logic               req_raise;
  logic               rd_clr;

  assign rd_clr = reg_rd;

  evt_irq_flag_bank #(.NUM_SRC(NUM_SRC)) flag_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (src_evt),
    .clr      (rd_clr),
    .flags_q  (flags_q),
    .flags_nx (flags_nx)
  );

  evt_irq_mask_reg #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) mask_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .wr_data (wr_data),
    .mask_q  (mask_q),
    .mask_nx (mask_nx)
  );

  evt_irq_req_gen #(.NUM_SRC(NUM_SRC)) req_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (rd_clr),
    .flags_nx (flags_nx),
    .mask_nx  (mask_nx),
    .raise    (req_raise),
    .req_q    (req_q)
  );

  if (GAP_W > 0) begin : g_rd_gap
    assign rd_data = {req_q, {GAP_W{1'b0}}, flags_q};
  end else begin : g_rd_nogap
    assign rd_data = {req_q, flags_q};
  end

  assign irq_n = ~req_q;
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
  parameter int NUM_SRC = evt_irq_pkg::DEF_NUM_SRC,
  parameter int REG_W   = evt_irq_pkg::DEF_REG_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_evt,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [REG_W-1:0]   wr_data,
  input logic               irq_n,
  input logic [NUM_SRC-1:0] flags_q,
  input logic [NUM_SRC-1:0] mask_q
);
  AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt != '0) |=> ((flags_q & $past(src_evt)) == $past(src_evt))); // R3

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && wr_data[REG_W-1]) |=>
      ((mask_q & $past(wr_data[NUM_SRC-1:0])) == $past(wr_data[NUM_SRC-1:0]))); // R2

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !wr_data[REG_W-1]) |=> ((mask_q & $past(wr_data[NUM_SRC-1:0])) == '0)); // R2

  AST_REQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (((flags_q & mask_q) != '0) && !reg_wr && !reg_rd) |=> !irq_n); // R4

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !reg_rd) |=> !irq_n); // R10

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (src_evt == '0)) |=> ((flags_q == '0) && irq_n)); // R5

  AST_RD_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (src_evt != '0)) |=> (flags_q == $past(src_evt))); // R8
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .src_evt (src_evt),
  .reg_wr  (reg_wr),
  .reg_rd  (reg_rd),
  .wr_data (wr_data),
  .irq_n   (irq_n),
  .flags_q (flags_q),
  .mask_q  (mask_q)
);

// File: tb/evt_irq_ctrl_tb_top.sv
module evt_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] src_evt = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq_n;

  int n_run = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  evt_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n)
  );

  // Fields: evt[23:19] wr[18] wdata[17:10] rd[9] exp_rd[8:1] exp_irq_n[0].
  // Expected values are what the ports show during the vector's own cycle.
  localparam int NV = 32;
  localparam logic [23:0] VEC [NV] = '{
    {5'b00001, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1}, // 0  timer A pulse
    {5'b00000, 1'b0, 8'h00, 1'b0, 8'h01, 1'b1}, // 1  R3 latched, masked
    {5'b00000, 1'b0, 8'h00, 1'b1, 8'h01, 1'b1}, // 2  R5 read shows flag
    {5'b00000, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1}, // 3  R5 cleared
    {5'b00000, 1'b1, 8'h81, 1'b0, 8'h00, 1'b1}, // 4  R2 enable timer A
    {5'b00010, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1}, // 5  timer B (disabled)
    {5'b00000, 1'b0, 8'h00, 1'b0, 8'h02, 1'b1}, // 6  R3 no request
    {5'b00001, 1'b0, 8'h00, 1'b0, 8'h02, 1'b1}, // 7  timer A
    {5'b00000, 1'b0, 8'h00, 1'b0, 8'h83, 1'b0}, // 8  R4 request, R1 bit 7
    {5'b10000, 1'b0, 8'h00, 1'b0, 8'h83, 1'b0}, // 9  external input
    {5'b00000, 1'b0, 8'h00, 1'b0, 8'h93, 1'b0}, // 10 R4 still asserted
    {5'b00000, 1'b1, 8'h01, 1'b0, 8'h93, 1'b0}, // 11 clear timer A enable
    {5'b00000, 1'b0, 8'h00, 1'b0, 8'h93, 1'b0}, // 12 R10 request kept
    {5'b00000, 1'b0, 8'h00, 1'b1, 8'h93, 1'b0}, // 13 read
    {5'b00000, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1}, // 14 R5 all cleared
    {5'b00100, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1}, // 15 alarm pulse
    {5'b00000, 1'b1, 8'h84, 1'b0, 8'h04, 1'b1}, // 16 enable alarm
    {5'b00000, 1'b0, 8'h00, 1'b0, 8'h84, 1'b0}, // 17 R6 pending raises
    {5'b01000, 1'b0, 8'h00, 1'b1, 8'h84, 1'b0}, // 18 read + serial event
    {5'b00000, 1'b0, 8'h00, 1'b0, 8'h08, 1'b1}, // 19 R8 survives, masked
    {5'b00000, 1'b1, 8'h88, 1'b0, 8'h08, 1'b1}, // 20 enable serial
    {5'b00000, 1'b0, 8'h00, 1'b0, 8'h88, 1'b0}, // 21 R6 again
    {5'b00100, 1'b0, 8'h00, 1'b1, 8'h88, 1'b0}, // 22 read + alarm event
    {5'b00000, 1'b0, 8'h00, 1'b0, 8'h84, 1'b0}, // 23 R8 enabled survivor
    {5'b00000, 1'b1, 8'h7F, 1'b0, 8'h84, 1'b0}, // 24 R2 clear all enables
    {5'b00000, 1'b0, 8'h00, 1'b1, 8'h84, 1'b0}, // 25 R10 held until read
    {5'b11111, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1}, // 26 all sources at once
    {5'b00000, 1'b0, 8'h00, 1'b0, 8'h1F, 1'b1}, // 27 R1 positions, R2 no enables
    {5'b00000, 1'b1, 8'hFF, 1'b0, 8'h1F, 1'b1}, // 28 set all, stray 6:5
    {5'b00000, 1'b0, 8'h00, 1'b0, 8'h9F, 1'b0}, // 29 R6 R1 gap bits zero
    {5'b00000, 1'b0, 8'h00, 1'b1, 8'h9F, 1'b0}, // 30 read
    {5'b00000, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1}  // 31 R5 idle
  };

  task automatic check(input string tag, input logic [7:0] exp_rd, input logic exp_irq);
    n_run++;
    if (rd_data !== exp_rd || irq_n !== exp_irq) begin
      n_bad++;
      $display("FAIL %s: rd_data=%h irq_n=%b expected rd_data=%h irq_n=%b",
               tag, rd_data, irq_n, exp_rd, exp_irq);
    end
  endtask

  task automatic drive(input logic [4:0] e, input logic w, input logic [7:0] d, input logic r);
    @(negedge clk);
    src_evt = e; reg_wr = w; wr_data = d; reg_rd = r;
    #1;
  endtask

  task automatic idle_cycle();
    drive(5'b0, 1'b0, 8'h00, 1'b0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R7 reset state", 8'h00, 1'b1);
    rst_n = 1'b1;
    idle_cycle();
    check("R7 after release", 8'h00, 1'b1);

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VEC[i];
      drive(v[23:19], v[18], v[17:10], v[9]);
      check($sformatf("vector %0d", i), v[8:1], v[0]);
    end

    // R9: level held over many cycles with no read.
    drive(5'b00000, 1'b1, 8'h82, 1'b0);
    drive(5'b00010, 1'b0, 8'h00, 1'b0);
    for (int k = 0; k < 6; k++) begin
      idle_cycle();
      check("R9 level held", 8'h82, 1'b0);
    end

    // R7: reset mid-run clears flags, request and mask.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R7 async reset clears", 8'h00, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    drive(5'b00010, 1'b0, 8'h00, 1'b0);
    idle_cycle();
    check("R7 mask cleared by reset", 8'h02, 1'b1);
    drive(5'b00000, 1'b0, 8'h00, 1'b1);
    idle_cycle();
    check("R5 final read clear", 8'h00, 1'b1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule